// File: doc/BRIEF.md
# Low-power weighted-toggle pseudorandom scan-data generator

The block supplies pseudorandom shift data to a bank of scan chains and lets the user choose how often those chains switch. A linear-feedback generator advances on every clock. Each scan-chain input sits behind its own hold register. That register takes a fresh generator bit on a shift cycle only when two conditions hold: its per-chain control bit allows it, and the global phase is a toggle interval. In every other case it keeps its last value, so the chain sees no transition.

The per-chain control bits come from a staging register. During each pattern, one weighted random bit per shift cycle is shifted into that register. The weight is set by a 4-bit switching code. When a new pattern starts, the staged bits are copied into the control register. A phase flip-flop with a down counter splits the shift period into alternating toggle and hold intervals. Each interval has its own programmable length.

A pattern is started by pulsing `pat_start`. Shifting is then done by raising `shift_en`. The number of chains must not exceed 17, so that chain data bits and weighting bits come from separate generator stages.

Top module: `lp_toggle_prpg`

## Requirements
- R1: While reset is asserted, and immediately after it, `chain_out` is all zeros. The generator holds the seed 32'hACE12468, the control and staging registers are zero, the phase is toggle and the phase counter is zero.
- R2: The generator is a 32-bit shift-left register that advances on every clock. The new bit 0 is the XOR of state bits 31, 21, 1 and 0, and the state is never all zeros.
- R3: With `sw_code` = 0, every shift cycle loads `chain_out[i]` with bit i of the generator state of that cycle. This applies to all chains, whatever the phase or the control bits.
- R4: On each shift cycle without `pat_start`, the staging register shifts left by one and takes a new bit 0. For a code k from 1 to 15, that bit is the AND of generator bits 31 down to 32-k, so it is 1 with probability 2^-k. For code 0 the bit is 1.
- R5: A cycle with `pat_start` high copies the staging register into the control register. It sets the phase to toggle and loads the counter with `toggle_len`. In that cycle, `chain_out` and the staging register do not change, even if `shift_en` is high.
- R6: On a shift cycle in a toggle interval with a non-zero code, `chain_out[i]` loads generator bit i when control bit i is 1. When control bit i is 0, `chain_out[i]` keeps its value.
- R7: On a shift cycle in a hold interval with a non-zero code, no bit of `chain_out` changes.
- R8: Each interval lasts its setting plus one shift cycles: `toggle_len`+1 for a toggle interval and `hold_len`+1 for a hold interval. A shift cycle that finds the counter at zero flips the phase and loads the new interval's setting. Any other shift cycle decrements the counter.
- R9: While `hold_len` is 0, hold intervals are overridden and the chains behave as in a toggle interval.
- R10: A cycle with both `shift_en` and `pat_start` low changes neither `chain_out`, the staging register nor the phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pat_start | input | 1 | Pattern start strobe: reloads the control register and the phase |
| shift_en | input | 1 | Shift cycle enable |
| sw_code | input | 4 | Switching code: 0 turns low power off, 1 to 15 set the weight |
| toggle_len | input | 4 | Toggle interval length minus one, in shift cycles |
| hold_len | input | 4 | Hold interval length minus one, in shift cycles; 0 disables hold |
| chain_out | output | 8 | Scan-chain input data |

## Verification
A pattern start can land on the same cycle as a shift request, and that shift can also be the one that expires the phase counter. The reload must win: the chains stay put, the phase returns to toggle and the counter takes `toggle_len` rather than flipping. The bench drives random pattern starts over continuous and gapped shifting with short interval settings, so that this coincidence occurs many times. A behavioural reference model predicts `chain_out` on every clock, and each prediction is compared with the design's output.

// File: rtl/prpg_pkg.sv
package prpg_pkg;
  localparam int GEN_W  = 32;
  localparam int CODE_W = 4;
  localparam int MAX_K  = (1 << CODE_W) - 1;

  // one step of the generator: shift left, XOR feedback from taps 31,21,1,0
  function automatic logic [GEN_W-1:0] gen_step(input logic [GEN_W-1:0] s);
    logic fb;
    fb = s[31] ^ s[21] ^ s[1] ^ s[0];
    return {s[GEN_W-2:0], fb};
  endfunction

  // weighted enable: AND of the top k generator bits, 1 when k is 0
  function automatic logic weight_bit(input logic [GEN_W-1:0] s,
                                      input logic [CODE_W-1:0] k);
    logic acc;
    acc = 1'b1;
    for (int j = 0; j < MAX_K; j++) begin
      if (j < int'(k)) acc = acc & s[GEN_W-1-j];
    end
    return acc;
  endfunction

  // length loaded into the phase counter when an interval ends
  function automatic logic [CODE_W-1:0] next_len(input logic cur_toggle,
                                                 input logic [CODE_W-1:0] tl,
                                                 input logic [CODE_W-1:0] hl);
    return cur_toggle ? hl : tl;
  endfunction
endpackage

// File: rtl/prpg_gen.sv
module prpg_gen
  import prpg_pkg::*;
#(
  parameter logic [GEN_W-1:0] SEED = 32'hACE1_2468
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [GEN_W-1:0] gen_state
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gen_state <= SEED;
    else        gen_state <= gen_step(gen_state);
  end

  p_gen_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    gen_state != '0);

  p_gen_moves_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> gen_state[GEN_W-1:1] == $past(gen_state[GEN_W-2:0]));
endmodule

// File: rtl/prpg_ctrl_load.sv
module prpg_ctrl_load #(
  parameter int N_CHAINS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                shift_go,
  input  logic                pat_start,
  input  logic                wbit,
  output logic [N_CHAINS-1:0] staged,
  output logic [N_CHAINS-1:0] ctrl
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      staged <= '0;
      ctrl   <= '0;
    end else begin
      if (pat_start) ctrl <= staged;
      if (shift_go)  staged <= {staged[N_CHAINS-2:0], wbit};
    end
  end

  p_ctrl_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pat_start |=> ctrl == $past(staged));

  p_staged_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_go |=> $stable(staged));

  p_ctrl_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !pat_start |=> $stable(ctrl));
endmodule

// File: rtl/prpg_phase.sv
module prpg_phase
  import prpg_pkg::*;
#(
  parameter int DUR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_go,
  input  logic             pat_start,
  input  logic [DUR_W-1:0] toggle_len,
  input  logic [DUR_W-1:0] hold_len,
  output logic             phase_t,
  output logic             phase_on,
  output logic             expire
);
  logic [DUR_W-1:0] cnt;
  logic             no_hold;

  assign no_hold  = (hold_len == '0);
  assign phase_on = phase_t | no_hold;
  assign expire   = shift_go && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_t <= 1'b1;
      cnt     <= '0;
    end else if (pat_start) begin
      phase_t <= 1'b1;
      cnt     <= toggle_len;
    end else if (expire) begin
      phase_t <= ~phase_t;
      cnt     <= next_len(phase_t, toggle_len, hold_len);
    end else if (shift_go) begin
      cnt <= cnt - 1'b1;
    end
  end

  p_phase_flip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> phase_t != $past(phase_t));

  p_phase_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pat_start |=> phase_t && cnt == $past(toggle_len));

  p_phase_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_go && !pat_start) |=> $stable(phase_t) && $stable(cnt));

  p_no_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_len == '0) |-> phase_on);
endmodule

// File: rtl/lp_toggle_prpg.sv
module lp_toggle_prpg
  import prpg_pkg::*;
#(
  parameter int                N_CHAINS = 8,
  parameter int                DUR_W    = 4,
  parameter logic [GEN_W-1:0] SEED     = 32'hACE1_2468
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pat_start,
  input  logic                shift_en,
  input  logic [CODE_W-1:0]   sw_code,
  input  logic [DUR_W-1:0]    toggle_len,
  input  logic [DUR_W-1:0]    hold_len,
  output logic [N_CHAINS-1:0] chain_out
);
  logic [GEN_W-1:0]    gen_state;
  logic [N_CHAINS-1:0] staged;
  logic [N_CHAINS-1:0] ctrl;
  logic                shift_go;
  logic                lp_off;
  logic                wbit;
  logic                phase_t;
  logic                phase_on;
  logic                expire;
  logic [N_CHAINS-1:0] load_en;

  assign shift_go = shift_en & ~pat_start;
  assign lp_off   = (sw_code == '0);
  assign wbit     = weight_bit(gen_state, sw_code);

  prpg_gen #(.SEED(SEED)) u_gen (
    .clk(clk), .rst_n(rst_n), .gen_state(gen_state)
  );

  prpg_ctrl_load #(.N_CHAINS(N_CHAINS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .shift_go(shift_go), .pat_start(pat_start),
    .wbit(wbit), .staged(staged), .ctrl(ctrl)
  );

  prpg_phase #(.DUR_W(DUR_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .shift_go(shift_go), .pat_start(pat_start),
    .toggle_len(toggle_len), .hold_len(hold_len),
    .phase_t(phase_t), .phase_on(phase_on), .expire(expire)
  );

  // per-chain hold registers
  for (genvar i = 0; i < N_CHAINS; i++) begin : g_chain
    assign load_en[i] = shift_go & (lp_off | (phase_on & ctrl[i]));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          chain_out[i] <= 1'b0;
      else if (load_en[i]) chain_out[i] <= gen_state[i];
    end
  end

  p_lp_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_go && lp_off) |=> chain_out == $past(gen_state[N_CHAINS-1:0]));

  p_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_go && !lp_off) |=>
      ((chain_out ^ $past(chain_out)) & ~$past(ctrl)) == '0);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_go && !lp_off && !phase_t && hold_len != '0) |=> $stable(chain_out));

  p_start_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pat_start |=> $stable(chain_out));

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(chain_out));
endmodule

// File: tb/lp_toggle_prpg_bench.sv
`timescale 1ns/100ps
module lp_toggle_prpg_bench;
  localparam int N = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pat_start = 1'b0;
  logic       shift_en = 1'b0;
  logic [3:0] sw_code = 4'd0;
  logic [3:0] toggle_len = 4'd0;
  logic [3:0] hold_len = 4'd0;
  logic [N-1:0] chain_out;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  string cur_req = "R1";

  // reference model state
  logic [31:0]  m_gen;
  logic [N-1:0] m_stage, m_ctrl, m_out;
  logic         m_t;
  int           m_cnt;

  always #2.5 clk = ~clk;

  lp_toggle_prpg u_lp_toggle_prpg (
    .clk(clk), .rst_n(rst_n), .pat_start(pat_start), .shift_en(shift_en),
    .sw_code(sw_code), .toggle_len(toggle_len), .hold_len(hold_len),
    .chain_out(chain_out)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: chain_out=%h expected %h", req, cyc, act, exp);
    end
  endtask

  // behavioural model, one step per clock
  always @(posedge clk) begin
    logic [31:0]  g;
    logic         w, on;
    cyc++;
    if (!rst_n) begin
      m_gen = 32'hACE12468; m_stage = '0; m_ctrl = '0; m_out = '0;
      m_t = 1'b1; m_cnt = 0;
    end else begin
      g = m_gen;
      if (pat_start) begin
        m_ctrl = m_stage; m_t = 1'b1; m_cnt = toggle_len;
      end else if (shift_en) begin
        w = 1'b1;
        for (int j = 0; j < sw_code; j++) w = w & g[31-j];
        on = m_t || (hold_len == 0);
        for (int i = 0; i < N; i++)
          if (sw_code == 0 || (on && m_ctrl[i])) m_out[i] = g[i];
        m_stage = {m_stage[N-2:0], w};
        if (m_cnt == 0) begin
          m_cnt = m_t ? hold_len : toggle_len;
          m_t = ~m_t;
        end else m_cnt = m_cnt - 1;
      end
      m_gen = (g << 1) | {31'd0, ^(g & 32'h80200003)};
    end
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: cycle %0d reached, expected completion", cyc);
      summary();
      $finish;
    end
  end

  always @(negedge clk) check(cur_req, chain_out, m_out);

  task automatic shift_run(int n, int pct, int start_pct);
    repeat (n) begin
      @(negedge clk);
      shift_en  = ($urandom_range(99) < pct);
      pat_start = ($urandom_range(99) < start_pct);
    end
    @(negedge clk);
    shift_en = 1'b0; pat_start = 1'b0;
  endtask

  task automatic new_pattern(logic with_shift);
    @(negedge clk);
    pat_start = 1'b1; shift_en = with_shift;
    @(negedge clk);
    pat_start = 1'b0; shift_en = 1'b0;
  endtask

  initial begin
    cur_req = "R1 reset";
    repeat (3) @(negedge clk);
    check("R1", chain_out, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", chain_out, '0);

    cur_req = "R2 R3 low power off";
    sw_code = 4'd0;
    shift_run(60, 100, 0);
    shift_run(60, 60, 0);

    cur_req = "R4 R5 R6 R7 R8 weighted";
    sw_code = 4'd1; toggle_len = 4'd5; hold_len = 4'd3;
    shift_run(10, 100, 0);
    new_pattern(1'b0);
    shift_run(80, 100, 0);
    new_pattern(1'b1);
    shift_run(80, 100, 0);

    cur_req = "R4 R6 R8 code 2 and 15";
    sw_code = 4'd2; toggle_len = 4'd0; hold_len = 4'd1;
    shift_run(10, 100, 0);
    new_pattern(1'b1);
    shift_run(60, 100, 0);
    sw_code = 4'd15;
    shift_run(10, 100, 0);
    new_pattern(1'b0);
    shift_run(40, 100, 0);

    cur_req = "R9 no hold";
    sw_code = 4'd1; toggle_len = 4'd2; hold_len = 4'd0;
    new_pattern(1'b0);
    shift_run(80, 100, 0);

    cur_req = "R10 gapped shift";
    hold_len = 4'd2;
    shift_run(200, 40, 0);

    cur_req = "R5 R8 start with shift";
    for (int r = 0; r < 20; r++) begin
      sw_code    = 4'($urandom_range(3));
      toggle_len = 4'($urandom_range(3));
      hold_len   = 4'($urandom_range(3));
      shift_run(100, 80, 8);
    end

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule